// File: doc/BRIEF.md
# DSP Pointer Update Unit

This block works out the next value of a 32-bit address-pointer register used by DSP addressing modes. The register is packed: the low half carries the current index, and the high half carries a second operand whose meaning depends on the mode. In bit-reverse mode that operand is a step added with reversed carry, which produces the scrambled index sequence that radix-2 FFT passes need. In circular mode it is the length of a ring buffer, and a small signed offset moves the index around that ring.

The update itself is combinational and appears on `ptr_next` in the same cycle as the inputs. A registered copy of the result is also provided. It is loaded only when `in_valid` is high, and a strobe marks that copy one cycle later. Base-address addition, memory access and instruction decode are left to the surrounding pipeline. The unit only produces the new register value.

Top module: `ptr_step_unit`

## Requirements
- R1: The index occupies bits [15:0] of the pointer. Bits [31:16] of `ptr_next` always equal bits [31:16] of `ptr_in`, in both modes.
- R2: With `mode_circ` = 0 (bit-reverse mode), the new index is the 16-bit reversal (bit k moves to bit 15-k) of the sum of the reversed index and the reversed step held in bits [31:16].
- R3: In bit-reverse mode, a carry out of bit 15 of the reversed sum is dropped. For example, index 0xFFFF with step 0x8000 gives index 0x0000.
- R4: In bit-reverse mode, `offset_in` has no effect on `ptr_next`.
- R5: With `mode_circ` = 1 (circular mode) and a nonzero length in bits [31:16], the new index is the index plus `offset_in`, which is read as 10-bit two's complement. When the index is below the length and the offset magnitude is below the length, the new index is always below the length.
- R6: In circular mode, when index plus offset is negative, the length is added once. For example, length 100, index 2, offset -5 gives 97.
- R7: In circular mode, when index plus offset is at least the length, the length is subtracted once. A sum equal to the length gives 0.
- R8: In circular mode with length 0, the index is left unchanged.
- R9: On each rising clock edge with `in_valid` high, `ptr_q` takes the value of `ptr_next` and `out_valid` goes high for the next cycle. When `in_valid` is low, `ptr_q` holds and `out_valid` is low.
- R10: Asserting `rst_n` low clears `ptr_q` and `out_valid` at once, without waiting for a clock edge. After `rst_n` rises, the registers stay cleared through the next two rising edges and first capture on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronised inside the block |
| in_valid | input | 1 | Load enable for the output register |
| mode_circ | input | 1 | 0 = bit-reverse update, 1 = circular update |
| ptr_in | input | 32 | Current pointer: step or length in [31:16], index in [15:0] |
| offset_in | input | 10 | Signed offset used in circular mode |
| ptr_next | output | 32 | Updated pointer, combinational |
| ptr_q | output | 32 | Registered updated pointer |
| out_valid | output | 1 | High for one cycle after each captured update |

## Verification
Two corner cases are hard to reach from the ports with ordinary addressing values. The first is the dropped carry in bit-reverse mode, which only appears when the reversed sum overflows 16 bits. The second is the exact wrap boundary in circular mode, where index plus offset lands on the length or just below zero. The stimulus table therefore includes an all-ones index, sums that land exactly on the length, the extreme offsets +511 and -512 against a length just above them, and a length of 0xFFFF. Each entry holds expected values worked out by hand. Directed steps then check the hold behaviour, a reset applied in mid-run, and the two-edge delay before the first capture after reset is released.

// File: rtl/ptr_step_pkg.sv
package ptr_step_pkg;

  localparam int unsigned PTR_IDX_W = 16;
  localparam int unsigned PTR_OFS_W = 10;
  localparam int unsigned PTR_SYNC_STAGES = 2;

  typedef enum logic {
    STEP_BITREV = 1'b0,
    STEP_CIRC   = 1'b1
  } step_mode_e;

endpackage

// File: rtl/ptr_rst_sync.sv
module ptr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ptr_bitrev_step.sv
module ptr_bitrev_step #(
  parameter int unsigned IDX_W = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] step,
  output logic [IDX_W-1:0] idx_new
);

  logic [IDX_W-1:0] idx_rev;
  logic [IDX_W-1:0] step_rev;
  logic [IDX_W-1:0] sum_rev;

  for (genvar b = 0; b < IDX_W; b++) begin : g_mirror
    assign idx_rev[b]  = idx[IDX_W-1-b];
    assign step_rev[b] = step[IDX_W-1-b];
    assign idx_new[b]  = sum_rev[IDX_W-1-b];
  end

  // carry out of the top bit is dropped by the IDX_W-wide result
  always_comb begin
    sum_rev = idx_rev + step_rev;
  end

endmodule

// File: rtl/ptr_circ_step.sv
module ptr_circ_step #(
  parameter int unsigned IDX_W = 16,
  parameter int unsigned OFS_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] len,
  input  logic [OFS_W-1:0] ofs,
  output logic [IDX_W-1:0] idx_new
);

  localparam int unsigned SUM_W = IDX_W + 2;

  logic signed [SUM_W-1:0] raw_sum;
  logic signed [SUM_W-1:0] len_ext;
  logic signed [SUM_W-1:0] wrapped;
  logic                    is_neg;
  logic                    is_over;

  always_comb begin
    len_ext = $signed({2'b00, len});
    raw_sum = $signed({2'b00, idx}) + $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    is_neg  = raw_sum[SUM_W-1];
    is_over = !is_neg && (raw_sum >= len_ext);
    if (is_neg) begin
      wrapped = raw_sum + len_ext;
    end else if (is_over) begin
      wrapped = raw_sum - len_ext;
    end else begin
      wrapped = raw_sum;
    end
    if (len == '0) begin
      idx_new = idx;
    end else begin
      idx_new = wrapped[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/ptr_step_unit.sv
module ptr_step_unit
  import ptr_step_pkg::*;
#(
  parameter int unsigned IDX_W   = PTR_IDX_W,
  parameter int unsigned OFS_W   = PTR_OFS_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 mode_circ,
  input  logic [2*IDX_W-1:0]   ptr_in,
  input  logic [OFS_W-1:0]     offset_in,
  output logic [2*IDX_W-1:0]   ptr_next,
  output logic [2*IDX_W-1:0]   ptr_q,
  output logic                 out_valid
);

  localparam int unsigned PTR_W = 2 * IDX_W;

  step_mode_e       mode;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] upper;
  logic [IDX_W-1:0] br_idx;
  logic [IDX_W-1:0] cr_idx;
  logic [IDX_W-1:0] sel_idx;
  logic             rst_i;

  assign mode    = step_mode_e'(mode_circ);
  assign cur_idx = ptr_in[IDX_W-1:0];
  assign upper   = ptr_in[PTR_W-1:IDX_W];

  ptr_rst_sync #(.STAGES(PTR_SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  ptr_bitrev_step #(.IDX_W(IDX_W)) u_bitrev (
    .idx     (cur_idx),
    .step    (upper),
    .idx_new (br_idx)
  );

  ptr_circ_step #(.IDX_W(IDX_W), .OFS_W(OFS_W)) u_circ (
    .idx     (cur_idx),
    .len     (upper),
    .ofs     (offset_in),
    .idx_new (cr_idx)
  );

  always_comb begin
    unique case (mode)
      STEP_CIRC: sel_idx = cr_idx;
      default:   sel_idx = br_idx;
    endcase
    ptr_next = {upper, sel_idx};
  end

  // magnitude of the signed offset, for the range checks below
  logic [OFS_W-1:0] off_mag;
  assign off_mag = offset_in[OFS_W-1] ? (~offset_in + 1'b1) : offset_in;

  assert_bitrev_zero_step_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (!mode_circ && upper == '0) |-> (ptr_next[IDX_W-1:0] == cur_idx));

  assert_wrap_in_range_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_circ && upper != '0 && cur_idx < upper && IDX_W'(off_mag) < upper)
      |-> (ptr_next[IDX_W-1:0] < upper));

  assert_neg_wrap_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_circ && upper != '0 && offset_in[OFS_W-1] && IDX_W'(off_mag) > cur_idx
       && IDX_W'(off_mag) < upper)
      |-> (ptr_next[IDX_W-1:0] == upper - (IDX_W'(off_mag) - cur_idx)));

  assert_len_zero_hold_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_circ && upper == '0) |-> (ptr_next[IDX_W-1:0] == cur_idx));

  if (REG_OUT) begin : g_reg
    logic [PTR_W-1:0] q_r;
    logic [PTR_W-1:0] q_d;
    logic             v_r;
    logic             v_d;
    logic             cap_en;

    always_comb begin
      cap_en = in_valid;
      q_d    = ptr_next;
      v_d    = in_valid;
    end

    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) begin
        q_r <= '0;
      end else if (cap_en) begin
        q_r <= q_d;
      end
    end

    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) begin
        v_r <= 1'b0;
      end else begin
        v_r <= v_d;
      end
    end

    assign ptr_q     = q_r;
    assign out_valid = v_r;

    assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_i)
      in_valid |=> out_valid);
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_i)
      !in_valid |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_i)
      !in_valid |=> $stable(ptr_q));
    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_i)
      in_valid |=> (ptr_q == $past(ptr_next)));
  end else begin : g_comb
    assign ptr_q     = ptr_next;
    assign out_valid = in_valid & rst_i;
  end

endmodule

// File: tb/tb_ptr_step_unit.sv
`timescale 1ns/1ps
module tb_ptr_step_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mode_circ = 1'b0;
  logic [31:0] ptr_in = '0;
  logic [9:0]  offset_in = '0;
  logic [31:0] ptr_next;
  logic [31:0] ptr_q;
  logic        out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptr_step_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode_circ (mode_circ),
    .ptr_in    (ptr_in),
    .offset_in (offset_in),
    .ptr_next  (ptr_next),
    .ptr_q     (ptr_q),
    .out_valid (out_valid)
  );

  // {mode[74], ptr[73:42], offset[41:32], expected[31:0]}
  localparam int NV = 16;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 32'h8000_0000, 10'h000, 32'h8000_8000},
    {1'b0, 32'h8000_8000, 10'h000, 32'h8000_4000},
    {1'b0, 32'h8000_4000, 10'h000, 32'h8000_C000},
    {1'b0, 32'h8000_FFFF, 10'h000, 32'h8000_0000},
    {1'b0, 32'h0000_1234, 10'h000, 32'h0000_1234},
    {1'b0, 32'h0100_00FF, 10'h155, 32'h0100_01FF},
    {1'b1, 32'h0064_000A, 10'h005, 32'h0064_000F},
    {1'b1, 32'h0064_0062, 10'h005, 32'h0064_0003},
    {1'b1, 32'h0064_0002, 10'h3FB, 32'h0064_0061},
    {1'b1, 32'h0064_005F, 10'h005, 32'h0064_0000},
    {1'b1, 32'h0064_0000, 10'h000, 32'h0064_0000},
    {1'b1, 32'h0000_0033, 10'h007, 32'h0000_0033},
    {1'b1, 32'h0258_0257, 10'h1FF, 32'h0258_01FE},
    {1'b1, 32'h0258_0000, 10'h200, 32'h0258_0058},
    {1'b1, 32'hFFFF_FFFE, 10'h001, 32'hFFFF_0000},
    {1'b1, 32'h0001_0000, 10'h000, 32'h0001_0000}
  };

  function automatic string tag_of(int i);
    case (i)
      3:            return "R3";
      5:            return "R4";
      6, 10, 15:    return "R5";
      8, 13:        return "R6";
      7, 9, 12, 14: return "R7";
      11:           return "R8";
      default:      return "R2";
    endcase
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (2) @(posedge clk);
    #1;
    check32("R10 reset ptr_q", ptr_q, 32'h0);
    check1("R10 reset out_valid", out_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_circ = VEC[i][74];
      ptr_in    = VEC[i][73:42];
      offset_in = VEC[i][41:32];
      in_valid  = 1'b1;
      #1;
      check32(tag_of(i), ptr_next, VEC[i][31:0]);
      check32("R1 upper half", {ptr_next[31:16], 16'h0}, {ptr_in[31:16], 16'h0});
      @(posedge clk);
      #1;
      check32("R9 captured", ptr_q, VEC[i][31:0]);
      check1("R9 strobe", out_valid, 1'b1);
    end

    // R9: no capture while in_valid is low
    @(negedge clk);
    in_valid  = 1'b0;
    mode_circ = 1'b0;
    ptr_in    = 32'h8000_0000;
    @(posedge clk);
    #1;
    check32("R9 hold", ptr_q, 32'h0001_0000);
    check1("R9 strobe low", out_valid, 1'b0);

    // load a nonzero value, then reset in mid-run
    @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    check32("R2 reload", ptr_q, 32'h8000_8000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check32("R10 async clear ptr_q", ptr_q, 32'h0);
    check1("R10 async clear out_valid", out_valid, 1'b0);

    // R10: release, first capture on third edge
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check1("R10 edge1 still cleared", out_valid, 1'b0);
    @(posedge clk);
    #1;
    check1("R10 edge2 still cleared", out_valid, 1'b0);
    @(posedge clk);
    #1;
    check1("R10 edge3 capture", out_valid, 1'b1);
    check32("R10 edge3 value", ptr_q, 32'h8000_8000);

    @(negedge clk);
    in_valid = 1'b0;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule